// File: doc/BRIEF.md
# Fetch and Load-Use Hazard Controller

This block owns the front end of a five-stage integer pipeline. It holds the program counter, the fetch/decode register (instruction word plus a bubble flag) and the control half of the decode/execute register (bubble flag, instruction class and destination register). Every cycle it decodes the instruction in the fetch/decode register. From that it decides whether a load ahead of it forces an interlock. It also resolves jumps and zero-test branches, using an operand A supplied by the datapath's forwarding network. From these results it computes the next PC.

Jumps and branches are resolved in decode and never reach execute: they always leave a bubble in the decode/execute register. A load-use interlock freezes fetch and decode in place. An external stall request empties decode by injecting a bubble. A taken branch may still redirect the PC during that stall. The instruction memory is outside the block: it returns the word at `pc_o` on `imem_rdata_i` in the same cycle.

The pipeline advances on every clock edge with no handshake. Back-pressure arrives only through `stall_req_i` and the internal interlock, so all pins are plain control and data wires.

Top module: `fhc_fetch_ctrl`

## Requirements
- R1: The instruction fields are as follows. The opcode is bits [31:26], rs1 is [25:21], rs2 is [20:16] and rs3 is [15:11]. The short immediate is bits [15:0] sign-extended, and the long immediate is bits [25:0] sign-extended. Opcodes decode to classes as follows: 0x00 is register ALU (code 1), 0x08 to 0x0F are immediate ALU (code 2), 0x23 is load (code 3), 0x2B is store (code 4), 0x04 is beqz (code 5) and 0x02 is jump (code 6). Every other opcode is class other (code 0).
- R2: `load_use_stall_o` is 1 exactly when all of these hold: the decode/execute entry is not a bubble and has class load, the fetch/decode entry is not a bubble, and its rs1 or rs2 equals `idex_dest_o`.
- R3: While `load_use_stall_o` is 1, the next edge leaves `pc_o`, `ifid_instr_o` and `ifid_bubble_o` unchanged.
- R4: `branch_taken_o` is 1 exactly when the fetch/decode entry is not a bubble and one of these holds: its class is jump, or its class is beqz and `fwd_opa_i` is zero.
- R5: The jump target is the current `pc_o` plus the long immediate. The branch target is the current `pc_o` plus the short immediate. At that point `pc_o` already points past the branch.
- R6: With neither stall active, the next edge has these effects. `ifid_instr_o` takes `imem_rdata_i`. `ifid_bubble_o` takes `branch_taken_o`. `pc_o` becomes the target if the branch is taken, and `pc_o`+4 otherwise.
- R7: With `stall_req_i` at 1 and no load-use stall, the next edge sets `ifid_bubble_o` to 1 and holds `ifid_instr_o`. `pc_o` moves to the target if the branch is taken and holds otherwise.
- R8: The next `idex_bubble_o` is 1 in any of these cases: a load-use stall, a bubble in fetch/decode, or a jump or beqz in decode.
- R9: The next `idex_dest_o` is 0 for a bubble, a store, or class other. It is rs2 for load and immediate ALU, and rs3 for register ALU.
- R10: The next `idex_class_o` is the class code of the instruction in fetch/decode, even when a bubble is inserted.
- R11: While reset is held, `pc_o` is `RESET_PC` (default 0) and both bubble flags are 1. `ifid_instr_o` is 0, `idex_dest_o` is 0 and `idex_class_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_req_i | input | 1 | External stall request |
| imem_rdata_i | input | 32 | Instruction word read at `pc_o` |
| fwd_opa_i | input | XLEN | Forwarded operand A of the decode instruction |
| pc_o | output | XLEN | Program counter |
| ifid_instr_o | output | 32 | Fetch/decode instruction |
| ifid_bubble_o | output | 1 | Fetch/decode bubble flag |
| idex_bubble_o | output | 1 | Decode/execute bubble flag |
| idex_dest_o | output | 5 | Decode/execute destination register |
| idex_class_o | output | 3 | Decode/execute instruction class code |
| load_use_stall_o | output | 1 | Load-use interlock active this cycle |
| branch_taken_o | output | 1 | Decode redirects the PC this cycle |

## Verification
The timing of each output is fixed. `load_use_stall_o` and `branch_taken_o` are combinational, so they are valid in the same cycle as the inputs and the current register state. The PC, the two pipeline registers and the destination and class fields are all registered, so they change exactly one edge after the inputs that cause them. The bench drives inputs on the falling edge and checks the two flags shortly afterwards. It then lets one rising edge pass and compares every registered output at the next falling edge against values its own model predicted from the previous cycle.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_AW  = 5;
  localparam int CLS_W   = 3;

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RS1_LSB = OPC_LSB - REG_AW;
  localparam int RS2_LSB = RS1_LSB - REG_AW;
  localparam int RS3_LSB = RS2_LSB - REG_AW;
  localparam int IMM_S_W = 16;
  localparam int IMM_L_W = OPC_LSB;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER = 3'd0,
    CLS_ALUR  = 3'd1,
    CLS_ALUI  = 3'd2,
    CLS_LOAD  = 3'd3,
    CLS_STORE = 3'd4,
    CLS_BEQZ  = 3'd5,
    CLS_JUMP  = 3'd6
  } iclass_e;

  function automatic iclass_e classify(input logic [OPC_W-1:0] opc);
    iclass_e c;
    if (opc == 6'h00)                   c = CLS_ALUR;
    else if (opc[OPC_W-1:3] == 3'b001)  c = CLS_ALUI;
    else if (opc == 6'h23)              c = CLS_LOAD;
    else if (opc == 6'h2B)              c = CLS_STORE;
    else if (opc == 6'h04)              c = CLS_BEQZ;
    else if (opc == 6'h02)              c = CLS_JUMP;
    else                                c = CLS_OTHER;
    return c;
  endfunction
endpackage

// File: rtl/fhc_decode.sv
module fhc_decode
  import fhc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output iclass_e            cls,
  output logic [REG_AW-1:0]  rs1,
  output logic [REG_AW-1:0]  rs2,
  output logic [REG_AW-1:0]  rs3,
  output logic [XLEN-1:0]    imm_short,
  output logic [XLEN-1:0]    imm_long
);
  localparam int SPAD = XLEN - IMM_S_W;
  localparam int LPAD = XLEN - IMM_L_W;

  always_comb begin
    cls       = classify(instr[INSTR_W-1:OPC_LSB]);
    rs1       = instr[RS1_LSB +: REG_AW];
    rs2       = instr[RS2_LSB +: REG_AW];
    rs3       = instr[RS3_LSB +: REG_AW];
    imm_short = {{SPAD{instr[IMM_S_W-1]}}, instr[IMM_S_W-1:0]};
    imm_long  = {{LPAD{instr[IMM_L_W-1]}}, instr[IMM_L_W-1:0]};
  end
endmodule

// File: rtl/fhc_hazard.sv
module fhc_hazard
  import fhc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  iclass_e            dec_cls,
  input  logic [REG_AW-1:0]  dec_rs1,
  input  logic [REG_AW-1:0]  dec_rs2,
  input  logic [XLEN-1:0]    dec_imm_short,
  input  logic [XLEN-1:0]    dec_imm_long,
  input  logic               dec_bubble,
  input  logic               ex_bubble,
  input  iclass_e            ex_cls,
  input  logic [REG_AW-1:0]  ex_dest,
  input  logic [XLEN-1:0]    opa,
  input  logic [XLEN-1:0]    pc,
  output logic               lu_stall,
  output logic               taken,
  output logic [XLEN-1:0]    target
);
  logic src_hit;
  logic ex_is_load;
  logic opa_zero;

  always_comb begin
    ex_is_load = !ex_bubble && (ex_cls == CLS_LOAD);
    src_hit    = (dec_rs1 == ex_dest) || (dec_rs2 == ex_dest);
    lu_stall   = ex_is_load && !dec_bubble && src_hit;
    opa_zero   = (opa == '0);
    taken      = !dec_bubble &&
                 ((dec_cls == CLS_JUMP) || ((dec_cls == CLS_BEQZ) && opa_zero));
    target     = pc + ((dec_cls == CLS_JUMP) ? dec_imm_long : dec_imm_short);
  end
endmodule

// File: rtl/fhc_state.sv
module fhc_state
  import fhc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_req,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               lu_stall,
  input  logic               taken,
  input  logic [XLEN-1:0]    target,
  input  iclass_e            dec_cls,
  input  logic [REG_AW-1:0]  dec_rs2,
  input  logic [REG_AW-1:0]  dec_rs3,
  output logic [XLEN-1:0]    pc_q,
  output logic [INSTR_W-1:0] ifid_instr_q,
  output logic               ifid_bubble_q,
  output logic               idex_bubble_q,
  output logic [REG_AW-1:0]  idex_dest_q,
  output iclass_e            idex_cls_q
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0]    pc_d;
  logic [INSTR_W-1:0] instr_d;
  logic               ifid_bub_d;
  logic               idex_bub_d;
  logic [REG_AW-1:0]  dest_d;

  // fetch side: priority is interlock, then external stall, then advance
  always_comb begin
    pc_d       = pc_q;
    instr_d    = ifid_instr_q;
    ifid_bub_d = ifid_bubble_q;
    if (lu_stall) begin
      pc_d       = pc_q;
    end else if (stall_req) begin
      ifid_bub_d = 1'b1;
      pc_d       = taken ? target : pc_q;
    end else begin
      instr_d    = imem_rdata;
      ifid_bub_d = taken;
      pc_d       = taken ? target : pc_q + PC_STEP;
    end
  end

  // decode side: bubble and destination for execute
  always_comb begin
    idex_bub_d = lu_stall || ifid_bubble_q ||
                 (dec_cls == CLS_JUMP) || (dec_cls == CLS_BEQZ);
    if (idex_bub_d) begin
      dest_d = '0;
    end else begin
      unique case (dec_cls)
        CLS_LOAD, CLS_ALUI: dest_d = dec_rs2;
        CLS_ALUR:           dest_d = dec_rs3;
        default:            dest_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q          <= RESET_PC;
      ifid_instr_q  <= '0;
      ifid_bubble_q <= 1'b1;
      idex_bubble_q <= 1'b1;
      idex_dest_q   <= '0;
      idex_cls_q    <= CLS_OTHER;
    end else begin
      pc_q          <= pc_d;
      ifid_instr_q  <= instr_d;
      ifid_bubble_q <= ifid_bub_d;
      idex_bubble_q <= idex_bub_d;
      idex_dest_q   <= dest_d;
      idex_cls_q    <= dec_cls;
    end
  end
endmodule

// File: rtl/fhc_fetch_ctrl.sv
module fhc_fetch_ctrl
  import fhc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_req_i,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  input  logic [XLEN-1:0]    fwd_opa_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic               ifid_bubble_o,
  output logic               idex_bubble_o,
  output logic [REG_AW-1:0]  idex_dest_o,
  output logic [CLS_W-1:0]   idex_class_o,
  output logic               load_use_stall_o,
  output logic               branch_taken_o
);
  iclass_e           dec_cls;
  logic [REG_AW-1:0] dec_rs1, dec_rs2, dec_rs3;
  logic [XLEN-1:0]   dec_imm_s, dec_imm_l;
  logic [XLEN-1:0]   target;
  iclass_e           idex_cls;

  fhc_decode #(.XLEN(XLEN)) u_dec (
    .instr     (ifid_instr_o),
    .cls       (dec_cls),
    .rs1       (dec_rs1),
    .rs2       (dec_rs2),
    .rs3       (dec_rs3),
    .imm_short (dec_imm_s),
    .imm_long  (dec_imm_l)
  );

  fhc_hazard #(.XLEN(XLEN)) u_haz (
    .dec_cls       (dec_cls),
    .dec_rs1       (dec_rs1),
    .dec_rs2       (dec_rs2),
    .dec_imm_short (dec_imm_s),
    .dec_imm_long  (dec_imm_l),
    .dec_bubble    (ifid_bubble_o),
    .ex_bubble     (idex_bubble_o),
    .ex_cls        (idex_cls),
    .ex_dest       (idex_dest_o),
    .opa           (fwd_opa_i),
    .pc            (pc_o),
    .lu_stall      (load_use_stall_o),
    .taken         (branch_taken_o),
    .target        (target)
  );

  fhc_state #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_st (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_req     (stall_req_i),
    .imem_rdata    (imem_rdata_i),
    .lu_stall      (load_use_stall_o),
    .taken         (branch_taken_o),
    .target        (target),
    .dec_cls       (dec_cls),
    .dec_rs2       (dec_rs2),
    .dec_rs3       (dec_rs3),
    .pc_q          (pc_o),
    .ifid_instr_q  (ifid_instr_o),
    .ifid_bubble_q (ifid_bubble_o),
    .idex_bubble_q (idex_bubble_o),
    .idex_dest_q   (idex_dest_o),
    .idex_cls_q    (idex_cls)
  );

  assign idex_class_o = idex_cls;
endmodule

// File: rtl/fhc_fetch_ctrl_chk.sv
module fhc_fetch_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall_req_i,
  input logic [XLEN-1:0] pc_o,
  input logic [31:0]     ifid_instr_o,
  input logic            ifid_bubble_o,
  input logic            idex_bubble_o,
  input logic [4:0]      idex_dest_o,
  input logic            load_use_stall_o,
  input logic            branch_taken_o
);
  a_r3_interlock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    load_use_stall_o |=> ($stable(pc_o) && $stable(ifid_instr_o) && $stable(ifid_bubble_o)));

  a_r4_no_redirect_from_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_bubble_o |-> !branch_taken_o);

  a_r6_sequential_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_use_stall_o && !stall_req_i && !branch_taken_o) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  a_r7_ext_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req_i && !load_use_stall_o) |=> (ifid_bubble_o && $stable(ifid_instr_o)));

  a_r8_idex_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (load_use_stall_o || ifid_bubble_o) |=> idex_bubble_o);

  a_r9_bubble_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble_o |-> (idex_dest_o == 5'd0));
endmodule

bind fhc_fetch_ctrl fhc_fetch_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .stall_req_i      (stall_req_i),
  .pc_o             (pc_o),
  .ifid_instr_o     (ifid_instr_o),
  .ifid_bubble_o    (ifid_bubble_o),
  .idex_bubble_o    (idex_bubble_o),
  .idex_dest_o      (idex_dest_o),
  .load_use_stall_o (load_use_stall_o),
  .branch_taken_o   (branch_taken_o)
);

// File: tb/tb_fhc_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_fhc_fetch_ctrl;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stall_req_i = 1'b0;
  logic [31:0]     imem_rdata_i = '0;
  logic [XLEN-1:0] fwd_opa_i = '0;
  logic [XLEN-1:0] pc_o;
  logic [31:0]     ifid_instr_o;
  logic            ifid_bubble_o, idex_bubble_o;
  logic [4:0]      idex_dest_o;
  logic [2:0]      idex_class_o;
  logic            load_use_stall_o, branch_taken_o;

  always #4 clk = ~clk;

  fhc_fetch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stall_req_i(stall_req_i), .imem_rdata_i(imem_rdata_i),
    .fwd_opa_i(fwd_opa_i), .pc_o(pc_o), .ifid_instr_o(ifid_instr_o),
    .ifid_bubble_o(ifid_bubble_o), .idex_bubble_o(idex_bubble_o),
    .idex_dest_o(idex_dest_o), .idex_class_o(idex_class_o),
    .load_use_stall_o(load_use_stall_o), .branch_taken_o(branch_taken_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  logic [XLEN-1:0] m_pc;
  logic [31:0]     m_ins;
  logic            m_ifb, m_exb;
  logic [4:0]      m_dest;
  logic [2:0]      m_cls;

  function automatic logic [2:0] cls_of(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == 6'h00) return 3'd1;
    if (op >= 6'h08 && op <= 6'h0F) return 3'd2;
    if (op == 6'h23) return 3'd3;
    if (op == 6'h2B) return 3'd4;
    if (op == 6'h04) return 3'd5;
    if (op == 6'h02) return 3'd6;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] lo);
    return {op, a, b, lo};
  endfunction

  // one cycle: drive at negedge, check flags, predict, check after edge
  task automatic cycle(input logic [31:0] iw, input logic [XLEN-1:0] opa, input logic st);
    logic [2:0] c;
    logic lu, tk, nifb, nexb;
    logic [XLEN-1:0] tgt, npc;
    logic [31:0] nins;
    logic [4:0] nd;
    imem_rdata_i = iw;
    fwd_opa_i    = opa;
    stall_req_i  = st;
    #1;
    c  = cls_of(m_ins);
    lu = !m_exb && (m_cls == 3'd3) && !m_ifb &&
         ((m_ins[25:21] == m_dest) || (m_ins[20:16] == m_dest));
    tk = !m_ifb && ((c == 3'd6) || ((c == 3'd5) && (opa == '0)));
    tgt = (c == 3'd6) ? m_pc + {{6{m_ins[25]}}, m_ins[25:0]}
                      : m_pc + {{16{m_ins[15]}}, m_ins[15:0]};
    chk("R2 load_use_stall", 64'(load_use_stall_o), 64'(lu));
    chk("R4 branch_taken", 64'(branch_taken_o), 64'(tk));
    if (lu) begin
      npc = m_pc; nins = m_ins; nifb = m_ifb;
    end else if (st) begin
      npc = tk ? tgt : m_pc; nins = m_ins; nifb = 1'b1;
    end else begin
      npc = tk ? tgt : m_pc + 4; nins = iw; nifb = tk;
    end
    nexb = lu || m_ifb || (c == 3'd6) || (c == 3'd5);
    if (nexb || c == 3'd4 || c == 3'd0) nd = 5'd0;
    else if (c == 3'd1) nd = m_ins[15:11];
    else nd = m_ins[20:16];
    @(posedge clk);
    @(negedge clk);
    chk(lu ? "R3 pc hold" : (st ? "R7 pc" : "R5/R6 pc"), 64'(pc_o), 64'(npc));
    chk(lu ? "R3 instr hold" : (st ? "R7 instr hold" : "R6 instr"), 64'(ifid_instr_o), 64'(nins));
    chk(lu ? "R3 ifid bubble" : (st ? "R7 ifid bubble" : "R6 ifid bubble"),
        64'(ifid_bubble_o), 64'(nifb));
    chk("R8 idex bubble", 64'(idex_bubble_o), 64'(nexb));
    chk("R9 idex dest", 64'(idex_dest_o), 64'(nd));
    chk("R1 R10 idex class", 64'(idex_class_o), 64'(c));
    m_pc = npc; m_ins = nins; m_ifb = nifb; m_exb = nexb; m_dest = nd; m_cls = c;
  endtask

  function automatic logic [31:0] rnd_instr();
    logic [5:0] op;
    case ($urandom % 8)
      0: op = 6'h00;
      1: op = 6'h02;
      2: op = 6'h04;
      3: op = 6'h23;
      4: op = 6'h2B;
      5: op = 6'h08 + 6'($urandom % 8);
      6: op = 6'h23;
      default: op = 6'h3F;
    endcase
    return {op, 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 11'($urandom)};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R11 reset pc", 64'(pc_o), 64'(0));
    chk("R11 reset ifid bubble", 64'(ifid_bubble_o), 64'(1));
    chk("R11 reset idex bubble", 64'(idex_bubble_o), 64'(1));
    chk("R11 reset instr", 64'(ifid_instr_o), 64'(0));
    chk("R11 reset dest/class", 64'({idex_dest_o, idex_class_o}), 64'(0));
    m_pc = '0; m_ins = '0; m_ifb = 1'b1; m_exb = 1'b1; m_dest = '0; m_cls = '0;
    rst_n = 1'b1;

    // directed: load r3 then dependent add (R2, R3), then independent op
    cycle(mk(6'h23, 5'd1, 5'd3, 16'h0010), '1, 1'b0);
    cycle(mk(6'h00, 5'd3, 5'd2, {5'd4, 11'd0}), '1, 1'b0);
    cycle(mk(6'h08, 5'd5, 5'd6, 16'h0001), '1, 1'b0);
    cycle(mk(6'h08, 5'd5, 5'd6, 16'h0001), '1, 1'b0);
    cycle(mk(6'h08, 5'd5, 5'd6, 16'h0001), '1, 1'b0);
    // directed: backward jump (R5 negative long imm)
    cycle(mk(6'h02, 5'h1F, 5'h1F, 16'hFFF0), '1, 1'b0);
    cycle(mk(6'h00, 5'd7, 5'd7, 16'h0000), '1, 1'b0);
    cycle(mk(6'h00, 5'd7, 5'd7, 16'h0000), '1, 1'b0);
    // directed: beqz taken under external stall (R7), then beqz not taken
    cycle(mk(6'h04, 5'd2, 5'd0, 16'h0040), '0, 1'b0);
    cycle(mk(6'h00, 5'd1, 5'd1, 16'h0800), '0, 1'b1);
    cycle(mk(6'h04, 5'd2, 5'd0, 16'h0040), '0, 1'b0);
    cycle(mk(6'h00, 5'd1, 5'd1, 16'h0800), 32'd5, 1'b0);
    cycle(mk(6'h2B, 5'd1, 5'd1, 16'h0800), 32'd5, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      cycle(rnd_instr(), ($urandom % 2) ? '0 : XLEN'($urandom), ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule